// File: doc/BRIEF.md
# Register-Keyed Page Size Predictor

This block guesses the page size of a load or store before address translation finishes, so that the TLB can pick its set index from the right address bits. It keeps a small table with one entry per base-address register number, and each entry is one bit. When a lookup comes in, the block reads the entry for the base register, returns the predicted size, and forms the TLB set index from the address bits that the predicted size selects. Later the access resolves. The true page size then goes back into the table, and the block flags a mispredict when the true size differs from the size that was predicted for that access.

Only two page sizes are supported, 4 KiB and 64 KiB. The table starts at the small size after reset and returns to the small size on every thread switch, so code that maps only base pages never mispredicts. In group mode the low bits of the register number are ignored, and neighbouring registers then share one entry. The retry path that acts on a mispredict sits outside this block.

Top module: `pageSizePredictor`

## Requirements
- R1: After reset every table entry predicts the small size: `lkSizeLarge` reads 0 for every register number.
- R2: The lookup output `lkSizeLarge` is the stored size bit for the addressed entry. The encoding is 0 = 4 KiB and 1 = 64 KiB. This output is combinational from `lkReg` and `groupEn`.
- R3: When the prediction is 4 KiB, `lkIndex[5:0]` equals `lkAddr[17:12]`.
- R4: When the prediction is 64 KiB, `lkIndex[5:4]` equals `lkAddr[17:16]` (these bits keep their place) and `lkIndex[3:0]` equals `lkAddr[21:18]`.
- R5: A resolve that is strobed in cycle c writes `rsLarge` into its entry at the clock edge that ends cycle c+1. Lookups see the new value from cycle c+2 on.
- R6: `mispredict` is high in cycle c+1 exactly when a resolve was strobed in cycle c with `rsLarge` different from `rsPredLarge`. In every other cycle it is low.
- R7: A lookup of the entry being resolved sees the old value, both in the cycle of the resolve and in the cycle after it.
- R8: A `threadSwitch` in cycle c sets every entry to the small size at the end of cycle c. This clear overrides a resolve write that lands at the same edge. A resolve strobed in cycle c itself still writes at the end of cycle c+1.
- R9: With `groupEn` high, the two low bits of the register number are ignored for both lookup and resolve, so registers 8 to 11 share entry 8. With `groupEn` low, each register has its own entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| threadSwitch | input | 1 | Reinitialise every entry to the small size |
| groupEn | input | 1 | Share entries between registers by masking the low register bits |
| lkReg | input | 5 | Base register number of the lookup |
| lkAddr | input | 48 | Virtual address of the lookup |
| lkSizeLarge | output | 1 | Predicted size, 1 = 64 KiB |
| lkIndex | output | 6 | TLB set index for the predicted size |
| rsValid | input | 1 | Resolve strobe |
| rsReg | input | 5 | Base register number of the resolved access |
| rsLarge | input | 1 | True page size, 1 = 64 KiB |
| rsPredLarge | input | 1 | Size that was predicted for this access |
| mispredict | output | 1 | True size differed from the prediction |

## Verification
Three pairs of events can fall in the same cycle: a lookup and a resolve of the same entry, a thread switch and a resolve write that is still pending, and a thread switch and a fresh resolve. The bench creates each pair on purpose by driving both inputs in one cycle, or in adjacent cycles, and then reads back the affected entries through ordinary lookups. The expected result is that a lookup sees the old value until cycle c+2, that the clear wins over the pending write, and that a resolve strobed together with the switch still lands afterwards.

// File: rtl/psp_pkg.sv
package psp_pkg;

  // Strobes from the control half to the table in the datapath half.
  typedef struct packed {
    logic clearAll;  // thread switch: every entry back to the small size
    logic wrEn;      // write the pending resolve into the table
    logic wrLarge;   // value to write, 1 = large page
  } tblCmd_t;

  localparam tblCmd_t TBL_CMD_IDLE = '{clearAll: 1'b0, wrEn: 1'b0, wrLarge: 1'b0};

endpackage

// File: rtl/psp_ctrl.sv
module psp_ctrl
  import psp_pkg::*;
#(
  parameter int unsigned REG_W      = 5,
  parameter int unsigned GROUP_BITS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             threadSwitch,
  input  logic             groupEn,
  input  logic             rsValid,
  input  logic [REG_W-1:0] rsReg,
  input  logic             rsLarge,
  input  logic             rsPredLarge,
  output tblCmd_t          tblCmd,
  output logic [REG_W-1:0] wrSlot,
  output logic             mispredict
);

  localparam logic [REG_W-1:0] GROUP_MASK = REG_W'((1 << GROUP_BITS) - 1);

  logic             pendValid;
  logic [REG_W-1:0] pendSlot;
  logic             pendLarge;
  logic             missQ;
  logic [REG_W-1:0] rsSlot;

  // The group mode folds neighbouring register numbers onto one slot.
  always_comb begin
    rsSlot = groupEn ? (rsReg & ~GROUP_MASK) : rsReg;
  end

  // The resolve stage: capture the resolve now, write the table one cycle later.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendSlot  <= '0;
      pendLarge <= 1'b0;
      missQ     <= 1'b0;
    end else begin
      pendValid <= rsValid;
      missQ     <= rsValid && (rsLarge != rsPredLarge);
      if (rsValid) begin
        pendSlot  <= rsSlot;
        pendLarge <= rsLarge;
      end
    end
  end

  // The thread switch takes priority over a write landing at the same edge.
  always_comb begin
    tblCmd          = TBL_CMD_IDLE;
    tblCmd.clearAll = threadSwitch;
    tblCmd.wrEn     = pendValid && !threadSwitch;
    tblCmd.wrLarge  = pendLarge;
  end

  assign wrSlot     = pendSlot;
  assign mispredict = missQ;

endmodule

// File: rtl/psp_datapath.sv
module psp_datapath
  import psp_pkg::*;
#(
  parameter int unsigned REG_W       = 5,
  parameter int unsigned GROUP_BITS  = 2,
  parameter int unsigned ADDR_W      = 48,
  parameter int unsigned INDEX_W     = 6,
  parameter int unsigned SMALL_SHIFT = 12,
  parameter int unsigned LARGE_SHIFT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  tblCmd_t            tblCmd,
  input  logic [REG_W-1:0]   wrSlot,
  input  logic               groupEn,
  input  logic [REG_W-1:0]   lkReg,
  input  logic [ADDR_W-1:0]  lkAddr,
  output logic               lkSizeLarge,
  output logic [INDEX_W-1:0] lkIndex
);

  localparam int unsigned ENTRIES   = 1 << REG_W;
  localparam int unsigned MOVE_W    = LARGE_SHIFT - SMALL_SHIFT;
  localparam int unsigned KEEP_W    = INDEX_W - MOVE_W;
  localparam int unsigned MOVE_BASE = SMALL_SHIFT + INDEX_W;
  localparam logic [REG_W-1:0] GROUP_MASK = REG_W'((1 << GROUP_BITS) - 1);

  logic [ENTRIES-1:0] sizeTbl;
  logic [REG_W-1:0]   lkSlot;
  logic [INDEX_W-1:0] smallIdx;
  logic [INDEX_W-1:0] largeIdx;

  // One size bit per slot.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sizeTbl[e] <= 1'b0;
      end else if (tblCmd.clearAll) begin
        sizeTbl[e] <= 1'b0;
      end else if (tblCmd.wrEn && (wrSlot == REG_W'(e))) begin
        sizeTbl[e] <= tblCmd.wrLarge;
      end
    end
  end

  always_comb begin
    lkSlot      = groupEn ? (lkReg & ~GROUP_MASK) : lkReg;
    lkSizeLarge = sizeTbl[lkSlot];
  end

  // Small pages take the index straight above the small page offset. Large
  // pages keep the top index bits where they are, and the low bits that now
  // fall inside the page offset are fetched from just above the small window.
  always_comb begin
    smallIdx = lkAddr[SMALL_SHIFT +: INDEX_W];
    largeIdx = {lkAddr[LARGE_SHIFT +: KEEP_W], lkAddr[MOVE_BASE +: MOVE_W]};
    lkIndex  = lkSizeLarge ? largeIdx : smallIdx;
  end

endmodule

// File: rtl/pageSizePredictor.sv
module pageSizePredictor
  import psp_pkg::*;
#(
  parameter int unsigned REG_W       = 5,
  parameter int unsigned GROUP_BITS  = 2,
  parameter int unsigned ADDR_W      = 48,
  parameter int unsigned INDEX_W     = 6,
  parameter int unsigned SMALL_SHIFT = 12,
  parameter int unsigned LARGE_SHIFT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               threadSwitch,
  input  logic               groupEn,
  input  logic [REG_W-1:0]   lkReg,
  input  logic [ADDR_W-1:0]  lkAddr,
  output logic               lkSizeLarge,
  output logic [INDEX_W-1:0] lkIndex,
  input  logic               rsValid,
  input  logic [REG_W-1:0]   rsReg,
  input  logic               rsLarge,
  input  logic               rsPredLarge,
  output logic               mispredict
);

  tblCmd_t          tblCmd;
  logic [REG_W-1:0] wrSlot;

  psp_ctrl #(
    .REG_W(REG_W), .GROUP_BITS(GROUP_BITS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .threadSwitch(threadSwitch), .groupEn(groupEn),
    .rsValid(rsValid), .rsReg(rsReg), .rsLarge(rsLarge), .rsPredLarge(rsPredLarge),
    .tblCmd(tblCmd), .wrSlot(wrSlot), .mispredict(mispredict)
  );

  psp_datapath #(
    .REG_W(REG_W), .GROUP_BITS(GROUP_BITS), .ADDR_W(ADDR_W), .INDEX_W(INDEX_W),
    .SMALL_SHIFT(SMALL_SHIFT), .LARGE_SHIFT(LARGE_SHIFT)
  ) uData (
    .clk(clk), .rstN(rstN), .tblCmd(tblCmd), .wrSlot(wrSlot), .groupEn(groupEn),
    .lkReg(lkReg), .lkAddr(lkAddr), .lkSizeLarge(lkSizeLarge), .lkIndex(lkIndex)
  );

endmodule

// File: rtl/psp_chk.sv
module psp_chk #(
  parameter int unsigned REG_W       = 5,
  parameter int unsigned ADDR_W      = 48,
  parameter int unsigned INDEX_W     = 6,
  parameter int unsigned SMALL_SHIFT = 12,
  parameter int unsigned LARGE_SHIFT = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               threadSwitch,
  input logic [ADDR_W-1:0]  lkAddr,
  input logic               lkSizeLarge,
  input logic [INDEX_W-1:0] lkIndex,
  input logic               rsValid,
  input logic               rsLarge,
  input logic               rsPredLarge,
  input logic               mispredict
);

  localparam int unsigned MOVE_W = LARGE_SHIFT - SMALL_SHIFT;
  localparam int unsigned KEEP_W = INDEX_W - MOVE_W;

  // R8
  switch_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    threadSwitch |=> !lkSizeLarge);

  // R6
  miss_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    rsValid |=> (mispredict == $past(rsLarge != rsPredLarge)));

  // R6
  miss_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rsValid |=> !mispredict);

  // R3
  small_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkSizeLarge |-> (lkIndex == lkAddr[SMALL_SHIFT +: INDEX_W]));

  // R4
  large_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkSizeLarge |-> (lkIndex[INDEX_W-1 -: KEEP_W] == lkAddr[LARGE_SHIFT +: KEEP_W]));

endmodule

bind pageSizePredictor psp_chk #(
  .REG_W(REG_W), .ADDR_W(ADDR_W), .INDEX_W(INDEX_W),
  .SMALL_SHIFT(SMALL_SHIFT), .LARGE_SHIFT(LARGE_SHIFT)
) uChk (
  .clk(clk), .rstN(rstN), .threadSwitch(threadSwitch), .lkAddr(lkAddr),
  .lkSizeLarge(lkSizeLarge), .lkIndex(lkIndex), .rsValid(rsValid),
  .rsLarge(rsLarge), .rsPredLarge(rsPredLarge), .mispredict(mispredict)
);

// File: tb/tb_pageSizePredictor.sv
module tb_pageSizePredictor;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        threadSwitch = 1'b0;
  logic        groupEn = 1'b0;
  logic [4:0]  lkReg = '0;
  logic [47:0] lkAddr = '0;
  logic        lkSizeLarge;
  logic [5:0]  lkIndex;
  logic        rsValid = 1'b0;
  logic [4:0]  rsReg = '0;
  logic        rsLarge = 1'b0;
  logic        rsPredLarge = 1'b0;
  logic        mispredict;

  int cyc = 0;
  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    int    kind;   // 0 size, 1 index, 2 mispredict
    int    exp;
    string req;
  } expItem_t;

  expItem_t sbQ[$];

  pageSizePredictor dut (
    .clk(clk), .rstN(rstN), .threadSwitch(threadSwitch), .groupEn(groupEn),
    .lkReg(lkReg), .lkAddr(lkAddr), .lkSizeLarge(lkSizeLarge), .lkIndex(lkIndex),
    .rsValid(rsValid), .rsReg(rsReg), .rsLarge(rsLarge), .rsPredLarge(rsPredLarge),
    .mispredict(mispredict)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int idxSmall(logic [47:0] a);
    return int'(a[17:12]);
  endfunction

  function automatic int idxLarge(logic [47:0] a);
    return int'({a[17:16], a[21:18]});
  endfunction

  task automatic push(int due, int kind, int exp, string req);
    expItem_t it;
    it.due = due; it.kind = kind; it.exp = exp; it.req = req;
    sbQ.push_back(it);
  endtask

  task automatic drive(logic [4:0] lr, logic [47:0] la, logic grp, logic rv,
                       logic [4:0] rr, logic rl, logic rp, logic sw);
    lkReg = lr; lkAddr = la; groupEn = grp; rsValid = rv;
    rsReg = rr; rsLarge = rl; rsPredLarge = rp; threadSwitch = sw;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // The monitor compares every item that falls due in the current cycle.
  always @(negedge clk) begin
    int i = 0;
    while (i < sbQ.size()) begin
      if (sbQ[i].due == cyc) begin
        int act;
        act = (sbQ[i].kind == 0) ? int'(lkSizeLarge) :
              (sbQ[i].kind == 1) ? int'(lkIndex) : int'(mispredict);
        nRun++;
        if (act != sbQ[i].exp) begin
          nFail++;
          $display("FAIL %s kind %0d: actual %0d expected %0d (cycle %0d)",
                   sbQ[i].req, sbQ[i].kind, act, sbQ[i].exp, cyc);
        end
        sbQ.delete(i);
      end else begin
        i++;
      end
    end
  end

  localparam logic [47:0] A0 = 48'h0000_1234_5678;
  localparam logic [47:0] A1 = 48'h00AB_C3F5_A000;

  initial begin
    drive(0, A0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();

    // R1, R3: every register predicts small after reset
    for (int r = 0; r < 32; r += 5) begin
      drive(5'(r), A0, 0, 0, 0, 0, 0, 0);
      push(cyc, 0, 0, "R1");
      push(cyc, 1, idxSmall(A0), "R3");
      tick();
    end

    // R5, R6, R7: resolve reg 5 as large after a small prediction
    drive(5, A1, 0, 1, 5, 1, 0, 0);
    push(cyc, 0, 0, "R7");
    push(cyc + 1, 2, 1, "R6");
    tick();
    drive(5, A1, 0, 0, 0, 0, 0, 0);
    push(cyc, 0, 0, "R7");
    tick();
    drive(5, A1, 0, 0, 0, 0, 0, 0);
    push(cyc, 0, 1, "R5");
    push(cyc, 1, idxLarge(A1), "R4");
    push(cyc, 2, 0, "R6");
    tick();

    // R6: a correct prediction gives no mispredict; R2 neighbour untouched
    drive(6, A1, 0, 1, 5, 1, 1, 0);
    push(cyc, 0, 0, "R2");
    push(cyc + 1, 2, 0, "R6");
    tick();
    drive(5, A1, 0, 1, 5, 0, 1, 0);
    push(cyc + 1, 2, 1, "R6");
    tick();
    drive(5, A1, 0, 0, 0, 0, 0, 0);
    tick();
    drive(5, A0, 0, 0, 0, 0, 0, 0);
    push(cyc, 0, 0, "R5");
    push(cyc, 1, idxSmall(A0), "R3");
    tick();

    // R9: group mode shares entry 8 among registers 8 to 11
    drive(0, A0, 1, 1, 9, 1, 0, 0);
    tick();
    drive(0, A0, 0, 0, 0, 0, 0, 0);
    tick();
    drive(10, A1, 1, 0, 0, 0, 0, 0);
    push(cyc, 0, 1, "R9");
    push(cyc, 1, idxLarge(A1), "R4");
    tick();
    drive(10, A1, 0, 0, 0, 0, 0, 0);
    push(cyc, 0, 0, "R9");
    tick();
    drive(8, A1, 0, 0, 0, 0, 0, 0);
    push(cyc, 0, 1, "R2");
    tick();

    // R8: a switch overrides a write landing at the same edge
    drive(8, A1, 0, 1, 3, 1, 0, 0);
    tick();
    drive(8, A1, 0, 0, 0, 0, 0, 1);
    push(cyc, 0, 1, "R2");
    tick();
    drive(3, A1, 0, 0, 0, 0, 0, 0);
    push(cyc, 0, 0, "R8");
    tick();
    drive(8, A1, 0, 0, 0, 0, 0, 0);
    push(cyc, 0, 0, "R8");
    tick();

    // R8: a resolve strobed with the switch still lands afterwards
    drive(0, A1, 0, 1, 20, 1, 0, 0);
    tick();
    drive(0, A1, 0, 0, 0, 0, 0, 0);
    tick();
    drive(20, A1, 0, 1, 21, 1, 0, 1);
    push(cyc, 0, 1, "R2");
    tick();
    drive(20, A1, 0, 0, 0, 0, 0, 0);
    push(cyc, 0, 0, "R8");
    tick();
    drive(21, A1, 0, 0, 0, 0, 0, 0);
    push(cyc, 0, 1, "R8");
    tick();
    tick();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule